// File: doc/BRIEF.md
# Serial NOR Page-Program Command Engine

This block is the device-side command logic of a serial NOR flash. It listens on a four-wire serial link (chip select, serial clock, serial in, serial out) in clock mode 0 or mode 3. It decodes a small command set: write enable, read status, read data and page program. The serial pins are oversampled by the system clock, so the link runs well below the system clock rate.

A page-program frame is one opcode, a 24-bit address sent MSB first, and then data bytes. The data bytes go into a page-wide staging buffer. The write offset starts at the address's offset within the page and wraps within that page, so a later byte replaces an earlier one at the same offset. When chip select rises exactly on a byte boundary, the engine checks three things: the write-enable latch was set when the opcode arrived, the target page is outside the protected region, and the engine is idle. It then clears the write-enable latch, raises write-in-progress for a fixed number of system clocks, and folds the staged bytes into the behavioural array with a bitwise AND. Bits can therefore only go from 1 to 0.

The protected region is selected by a plain 3-bit configuration input that the status register mirrors. Address bits above the array size are ignored, so larger addresses alias into the array.

Top module: `spi_pp_engine`

## Requirements
- R1: After reset, the status register reads 0 apart from the protect field, and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x05 returns the status byte repeatedly for as long as chip select stays low. The status byte layout is: bit 0 = write in progress, bit 1 = write-enable latch, bits 4:2 = protect field, bits 7:5 = 0.
- R3: A page-program frame (opcode 0x02) that arrives while the write-enable latch is clear leaves the array unchanged.
- R4: Programming stores old AND new in each written byte, so no bit ever goes from 0 to 1.
- R5: Data byte k of a frame lands at page offset (start offset + k) modulo the page size, inside the addressed page. A short frame therefore writes exactly the bytes sent, at their requested addresses. Untouched offsets keep their contents.
- R6: If more bytes are sent than a page holds, the latest byte at each offset wins. Earlier bytes at that offset are discarded.
- R7: A page-program frame whose chip-select rise does not fall on a byte boundary after at least one data byte changes nothing. The write-enable latch stays set.
- R8: Let the protect field be L. If L = 0, nothing is protected. Otherwise the top min(2^(L-1), page count) pages are protected, and a page-program aimed at one of them changes nothing.
- R9: After a valid page-program, write-in-progress reads 1 for exactly max(PROG_CYCLES, PAGE_BYTES) system clocks, and then 0. The write-enable latch is 0 from the first cycle of that window.
- R10: While write-in-progress is 1, every opcode except 0x05 is ignored, including write enable.
- R11: Opcode 0x03 followed by a 24-bit address returns array bytes starting at that address and incrementing. Serial out changes only after a falling serial-clock edge. Input is sampled on rising edges, in both mode 0 and mode 3.
- R12: Write enable takes effect only if chip select rises immediately after the eighth bit of the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) or idle high (mode 3) |
| si | input | 1 | Serial data into the device, MSB first |
| so | output | 1 | Serial data out of the device, updated after falling serial-clock edges |
| bp_cfg | input | 3 | Protect field that selects the protected top region |

## Verification
The bench builds the engine with a 2048-byte array of eight 256-byte pages and PROG_CYCLES set to 600. With only eight pages, protect levels 1 and 2 cover pages the bench can actually address, and the page boundary wrap sits at easily reached addresses. The 600-clock busy window is short enough to poll to completion, yet long enough for a whole write-enable frame and a status read to land inside it. A 258-byte frame overruns the page by two bytes and shows which copy survives at each offset.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_DATA, ST_STAT, ST_READ, ST_WEN, ST_IGN
  } cmd_st_t;

  typedef enum logic {K_PROG, K_READ} acc_kind_t;
endpackage

// File: rtl/spi_pp_sync.sv
module spi_pp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic cs_rise,
  output logic si_s
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0]  sck_p;
  logic [DEPTH-1:0]  cs_p;
  logic [STAGES-1:0] si_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[DEPTH-2:0], sck};
      cs_p  <= {cs_p[DEPTH-2:0], cs_n};
      si_p  <= {si_p[STAGES-2:0], si};
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_hi    = cs_p[STAGES-1];
  assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign si_s     = si_p[STAGES-1];
endmodule

// File: rtl/spi_pp_pagebuf.sv
module spi_pp_pagebuf #(
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_off,
  input  logic [7:0]                    wr_data,
  input  logic                          start,
  output logic                          arr_we,
  output logic [$clog2(PAGE_BYTES)-1:0] arr_off,
  output logic [7:0]                    arr_data
);
  localparam int PG_AW = $clog2(PAGE_BYTES);
  localparam logic [PG_AW-1:0] LAST = PG_AW'(PAGE_BYTES - 1);

  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic                  sweep_q;
  logic [PG_AW-1:0]      idx_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= 1'b0;
      idx_q   <= '0;
    end else if (start) begin
      sweep_q <= 1'b1;
      idx_q   <= '0;
    end else if (sweep_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) sweep_q <= 1'b0;
    end
  end

  assign arr_we   = sweep_q & vld_q[idx_q];
  assign arr_off  = idx_q;
  assign arr_data = slot_q[idx_q];
endmodule

// File: rtl/spi_pp_array.sv
module spi_pp_array #(
  parameter int MEM_BYTES = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(MEM_BYTES)-1:0] waddr,
  input  logic [7:0]                   wdata,
  input  logic [$clog2(MEM_BYTES)-1:0] raddr,
  output logic [7:0]                   rdata
);
  logic [7:0] cell_q [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) cell_q[i] <= 8'hFF;
    end else if (we) begin
      cell_q[waddr] <= cell_q[waddr] & wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/spi_pp_engine.sv
module spi_pp_engine
  import spi_pp_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 256,
  parameter int PROG_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  output logic       so,
  input  logic [2:0] bp_cfg
);
  localparam int MEM_AW    = $clog2(MEM_BYTES);
  localparam int PG_AW     = $clog2(PAGE_BYTES);
  localparam int PGN_W     = MEM_AW - PG_AW;
  localparam int NUM_PAGES = MEM_BYTES / PAGE_BYTES;
  localparam int PROG_LEN  = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;
  localparam int CNT_W     = $clog2(PROG_LEN + 1);

  logic sck_rise, sck_fall, cs_hi, cs_rise, si_s;

  cmd_st_t          st_q;
  acc_kind_t        kind_q;
  logic [2:0]       bit_q;
  logic [1:0]       acnt_q;
  logic [6:0]       rx_q;
  logic [MEM_AW-1:0] addr_q, rd_ptr_q, new_addr, raddr;
  logic [PG_AW-1:0] wr_off_q;
  logic             got_q, wel_q, busy_q, so_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       tx_q, rx_byte, status, rd_data;
  logic [PGN_W-1:0] pg_commit_q, pg_now;
  logic             byte_done, pb_clr, pb_wr, commit_ok, prot_hit;
  logic             arr_we;
  logic [PG_AW-1:0] arr_off;
  logic [7:0]       arr_data;
  int               prot_span;

  spi_pp_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_hi(cs_hi),
    .cs_rise(cs_rise), .si_s(si_s)
  );

  assign rx_byte   = {rx_q, si_s};
  assign new_addr  = MEM_AW'({addr_q, rx_byte});
  assign status    = {3'b000, bp_cfg, wel_q, busy_q};
  assign byte_done = sck_rise & ~cs_hi & (bit_q == 3'd7);
  assign pg_now    = addr_q[MEM_AW-1:PG_AW];
  assign raddr     = (st_q == ST_ADDR) ? new_addr : rd_ptr_q;

  always_comb begin
    prot_span = 0;
    if (bp_cfg != 3'd0)
      prot_span = ((int'(bp_cfg) - 1) >= PGN_W) ? NUM_PAGES : (1 << (int'(bp_cfg) - 1));
    prot_hit = (bp_cfg != 3'd0) && (int'(pg_now) >= (NUM_PAGES - prot_span));
  end

  assign pb_clr    = byte_done && (st_q == ST_OP) && (rx_byte == OP_PROG) && wel_q && !busy_q;
  assign pb_wr     = byte_done && (st_q == ST_DATA);
  assign commit_ok = cs_rise && (st_q == ST_DATA) && (bit_q == 3'd0) && got_q &&
                     !prot_hit && !busy_q;

  // command framing, latch and serial-out path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OP;
      kind_q   <= K_PROG;
      bit_q    <= '0;
      acnt_q   <= '0;
      rx_q     <= '0;
      addr_q   <= '0;
      rd_ptr_q <= '0;
      wr_off_q <= '0;
      got_q    <= 1'b0;
      wel_q    <= 1'b0;
      tx_q     <= '0;
      so_q     <= 1'b0;
    end else if (cs_hi) begin
      st_q   <= ST_OP;
      bit_q  <= '0;
      acnt_q <= '0;
      got_q  <= 1'b0;
      so_q   <= 1'b0;
      if (cs_rise && (st_q == ST_WEN) && !busy_q) wel_q <= 1'b1;
      if (commit_ok) wel_q <= 1'b0;
    end else begin
      if (sck_fall) begin
        so_q <= tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
      end
      if (sck_rise) begin
        rx_q  <= rx_byte[6:0];
        bit_q <= bit_q + 3'd1;
        if (st_q == ST_WEN) st_q <= ST_IGN;
        if (bit_q == 3'd7) begin
          case (st_q)
            ST_OP: begin
              if (busy_q && (rx_byte != OP_STAT)) begin
                st_q <= ST_IGN;
              end else if (rx_byte == OP_WEN) begin
                st_q <= ST_WEN;
              end else if (rx_byte == OP_STAT) begin
                st_q <= ST_STAT;
                tx_q <= status;
              end else if (rx_byte == OP_PROG) begin
                st_q   <= wel_q ? ST_ADDR : ST_IGN;
                kind_q <= K_PROG;
              end else if (rx_byte == OP_READ) begin
                st_q   <= ST_ADDR;
                kind_q <= K_READ;
              end else begin
                st_q <= ST_IGN;
              end
            end
            ST_ADDR: begin
              addr_q <= new_addr;
              acnt_q <= acnt_q + 2'd1;
              if (acnt_q == 2'd2) begin
                if (kind_q == K_PROG) begin
                  st_q     <= ST_DATA;
                  wr_off_q <= new_addr[PG_AW-1:0];
                end else begin
                  st_q     <= ST_READ;
                  tx_q     <= rd_data;
                  rd_ptr_q <= new_addr + 1'b1;
                end
              end
            end
            ST_DATA: begin
              wr_off_q <= wr_off_q + 1'b1;
              got_q    <= 1'b1;
            end
            ST_STAT: tx_q <= status;
            ST_READ: begin
              tx_q     <= rd_data;
              rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // busy window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      pg_commit_q <= '0;
    end else if (commit_ok) begin
      busy_q      <= 1'b1;
      cnt_q       <= CNT_W'(PROG_LEN - 1);
      pg_commit_q <= pg_now;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  spi_pp_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr_en(pb_wr),
    .wr_off(wr_off_q), .wr_data(rx_byte), .start(commit_ok),
    .arr_we(arr_we), .arr_off(arr_off), .arr_data(arr_data)
  );

  spi_pp_array #(.MEM_BYTES(MEM_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we),
    .waddr({pg_commit_q, arr_off}), .wdata(arr_data),
    .raddr(raddr), .rdata(rd_data)
  );

  assign so = so_q;
endmodule

// File: rtl/spi_pp_engine_chk.sv
module spi_pp_engine_chk #(
  parameter int PROG_LEN = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic wip,
  input logic wel,
  input logic so,
  input logic sck_fall,
  input logic cs_hi,
  input logic arr_we
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_cnt <= '0;
    else if (wip) run_cnt <= run_cnt + 32'd1;
    else          run_cnt <= '0;
  end

  // R9
  wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run_cnt == 32'(PROG_LEN)));

  // R9
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);

  // R10
  wel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(wip));

  // R4
  array_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wip);

  // R11
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_hi) |=> $stable(so));

  // R7
  start_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> cs_hi);
endmodule

bind spi_pp_engine spi_pp_engine_chk #(.PROG_LEN(PROG_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wip(busy_q), .wel(wel_q), .so(so),
  .sck_fall(sck_fall), .cs_hi(cs_hi), .arr_we(arr_we)
);

// File: tb/spi_pp_engine_test.sv
module spi_pp_engine_test;
  localparam int HALF = 8;
  localparam int PROG = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so;
  logic [2:0] bp_cfg = 3'd0;
  logic mode3 = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] pdata [300];

  always #4 clk = ~clk;

  spi_pp_engine #(.MEM_BYTES(2048), .PAGE_BYTES(256), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .bp_cfg(bp_cfg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fbegin();
    sck = mode3;
    idle(HALF);
    cs_n = 1'b0;
    idle(HALF);
  endtask

  task automatic fend();
    if (!mode3) sck = 1'b0;
    idle(HALF);
    cs_n = 1'b1;
    sck = mode3;
    idle(4 * HALF);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0;
      si = tx[i];
      idle(HALF);
      rx[i] = so;
      sck = 1'b1;
      idle(HALF);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xbyte(a[23:16], d);
    xbyte(a[15:8], d);
    xbyte(a[7:0], d);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    fbegin();
    xbyte(8'h05, d);
    xbyte(8'h00, s);
    fend();
  endtask

  task automatic rd_byte(input logic [23:0] a, output logic [7:0] v);
    logic [7:0] d;
    fbegin();
    xbyte(8'h03, d);
    send_addr(a);
    xbyte(8'h00, v);
    fend();
  endtask

  task automatic wren();
    logic [7:0] d;
    fbegin();
    xbyte(8'h06, d);
    fend();
  endtask

  task automatic pp(input logic [23:0] a, input int n, input int tail_bits);
    logic [7:0] d;
    fbegin();
    xbyte(8'h02, d);
    send_addr(a);
    for (int k = 0; k < n; k++) xbyte(pdata[k], d);
    if (tail_bits > 0) xbits(8'hFF, tail_bits, d);
    fend();
  endtask

  task automatic wait_done();
    logic [7:0] s;
    idle(PROG + 100);
    rd_status(s);
    chk("R9 wip clear", s & 8'h01, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_status(v);
    chk("R1 status", v, 8'h00);
    rd_byte(24'h000000, v);
    chk("R1 erased", v, 8'hFF);
    rd_byte(24'h0007FF, v);
    chk("R1 erased top", v, 8'hFF);
  endtask

  task automatic t_wren();
    logic [7:0] v, d;
    fbegin();
    xbyte(8'h06, d);
    xbits(8'h00, 1, d);
    fend();
    rd_status(v);
    chk("R12 nine-bit wren", v, 8'h00);
    wren();
    rd_status(v);
    chk("R2 wel set", v, 8'h02);
    fbegin();
    xbyte(8'h05, d);
    xbyte(8'h00, v);
    chk("R2 status first", v, 8'h02);
    xbyte(8'h00, v);
    chk("R2 status repeat", v, 8'h02);
    fend();
  endtask

  task automatic t_no_wel();
    logic [7:0] v;
    // latch is set from t_wren: run a real program to clear it first
    pdata[0] = 8'h00;
    pp(24'h000080, 1, 0);
    wait_done();
    pdata[0] = 8'h12;
    pp(24'h000090, 1, 0);
    idle(50);
    rd_byte(24'h000090, v);
    chk("R3 no latch", v, 8'hFF);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    wren();
    pdata[0] = 8'hA5; pdata[1] = 8'h3C; pdata[2] = 8'h0F;
    pp(24'h000010, 3, 0);
    rd_status(v);
    chk("R9 busy right after", v, 8'h01);
    wait_done();
    rd_byte(24'h000010, v); chk("R5 byte0", v, 8'hA5);
    rd_byte(24'h000011, v); chk("R5 byte1", v, 8'h3C);
    rd_byte(24'h000012, v); chk("R5 byte2", v, 8'h0F);
    rd_byte(24'h000013, v); chk("R5 untouched", v, 8'hFF);
    wren();
    pdata[0] = 8'hF0;
    pp(24'h000010, 1, 0);
    wait_done();
    rd_byte(24'h000010, v); chk("R4 and", v, 8'hA0);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wren();
    pdata[0] = 8'h11; pdata[1] = 8'h22; pdata[2] = 8'h33; pdata[3] = 8'h44;
    pp(24'h0001FE, 4, 0);
    wait_done();
    rd_byte(24'h0001FE, v); chk("R5 wrap fe", v, 8'h11);
    rd_byte(24'h0001FF, v); chk("R5 wrap ff", v, 8'h22);
    rd_byte(24'h000100, v); chk("R5 wrap 00", v, 8'h33);
    rd_byte(24'h000101, v); chk("R5 wrap 01", v, 8'h44);
    rd_byte(24'h000200, v); chk("R5 next page", v, 8'hFF);
  endtask

  task automatic t_over();
    logic [7:0] v;
    for (int k = 0; k < 258; k++) pdata[k] = 8'(k * 7 + 3);
    pdata[256] = 8'h81;
    pdata[257] = 8'h42;
    wren();
    pp(24'h000200, 258, 0);
    wait_done();
    rd_byte(24'h000200, v); chk("R6 off0", v, 8'h81);
    rd_byte(24'h000201, v); chk("R6 off1", v, 8'h42);
    rd_byte(24'h000202, v); chk("R6 off2", v, 8'(2 * 7 + 3));
    rd_byte(24'h0002FF, v); chk("R6 off255", v, 8'(255 * 7 + 3));
  endtask

  task automatic t_misalign();
    logic [7:0] v;
    wren();
    pdata[0] = 8'h00; pdata[1] = 8'h00;
    pp(24'h000300, 2, 3);
    idle(50);
    rd_byte(24'h000300, v); chk("R7 no change", v, 8'hFF);
    rd_status(v); chk("R7 latch kept", v, 8'h02);
    fbegin();
    xbyte(8'h02, v);
    send_addr(24'h000310);
    fend();
    rd_status(v); chk("R7 no data byte", v, 8'h02);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    bp_cfg = 3'd1;
    pdata[0] = 8'h55;
    pp(24'h000700, 1, 0);
    idle(50);
    rd_status(v); chk("R8 not started", v, 8'h06);
    rd_byte(24'h000700, v); chk("R8 top page kept", v, 8'hFF);
    pp(24'h000600, 1, 0);
    wait_done();
    rd_byte(24'h000600, v); chk("R8 level1 open page", v, 8'h55);
    bp_cfg = 3'd2;
    wren();
    pp(24'h000610, 1, 0);
    idle(50);
    rd_byte(24'h000610, v); chk("R8 level2 page6", v, 8'hFF);
    bp_cfg = 3'd0;
    pp(24'h000610, 1, 0);
    wait_done();
    rd_byte(24'h000610, v); chk("R8 unprotected", v, 8'h55);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    wren();
    pdata[0] = 8'h77;
    pp(24'h000400, 1, 0);
    wren();
    rd_status(v);
    chk("R10 status during busy", v, 8'h01);
    wait_done();
    rd_status(v);
    chk("R10 wren ignored", v, 8'h00);
    rd_byte(24'h000400, v);
    chk("R10 program done", v, 8'h77);
  endtask

  task automatic t_mode3();
    logic [7:0] v, d;
    mode3 = 1'b1;
    sck = 1'b1;
    idle(HALF);
    wren();
    pdata[0] = 8'hC3; pdata[1] = 8'h5A; pdata[2] = 8'h96;
    pp(24'h000500, 3, 0);
    wait_done();
    fbegin();
    xbyte(8'h03, d);
    send_addr(24'h000500);
    xbyte(8'h00, v); chk("R11 mode3 read0", v, 8'hC3);
    xbyte(8'h00, v); chk("R11 mode3 read1", v, 8'h5A);
    xbyte(8'h00, v); chk("R11 mode3 read2", v, 8'h96);
    fend();
    mode3 = 1'b0;
    sck = 1'b0;
    idle(HALF);
    rd_byte(24'h000501, v); chk("R11 mode0 read", v, 8'h5A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(10);
    rst_n = 1'b1;
    idle(10);
    t_reset();
    t_wren();
    t_no_wel();
    t_basic();
    t_wrap();
    t_over();
    t_misalign();
    t_protect();
    t_busy();
    t_mode3();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule